// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide host interface for a bank of up to three interval-timer channel cores. Four addresses are decoded: addresses 0 to NCH-1 are the per-channel data ports and address 3 is the control port. A control byte either reprograms one channel (access order, counting mode, decimal flag) or asks for a snapshot of that channel's running count. A readback control byte captures the count, the status byte or both for several channels in the same cycle.

The counting itself happens in the channel cores. They receive a 16-bit reload value with a one-cycle load pulse, the mode, the decimal flag and a gate level. They return their live count and output level. Each channel keeps its own byte-order toggles, so 16-bit values move through the 8-bit bus as two accesses. A pending status snapshot is always read out before a pending count snapshot. Read data is combinational from the current state and address. Read side effects take place at the clock edge that ends the read cycle. A cycle carries at most one access, either a read or a write.

Top module: `tmr_regif`

## Requirements
- R1: A write to address 3 with bits 7:6 equal to a channel number below NCH, and bits 5:4 non-zero, sets that channel's access order. The access order is 1 = low byte only, 2 = high byte only, 3 = low then high. The same write sets the mode to bits 3:1 and the decimal flag to bit 0, all visible on the channel outputs the next cycle. It also returns both of that channel's byte toggles to the low byte.
- R2: A control byte with bits 5:4 equal to 0 snapshots the channel's live count of that cycle, tagged with the current access order. While a snapshot is still unread, further snapshot requests are ignored. A snapshot is read out as follows: low-only order gives the low byte and clears it; high-only order gives the high byte and clears it; low-then-high order gives the low byte and then the high byte, and only the second read clears it.
- R3: A control byte with bits 7:6 equal to 3 is a readback command. Bit 1, bit 2 and bit 3 select channels 0, 1 and 2. For each selected channel, bit 5 low requests a count snapshot under the R2 rules, and bit 4 low requests a status snapshot. A status request is ignored while that channel already has a status snapshot pending.
- R4: The status byte holds the output level in bit 7, 0 in bit 6, the access order in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0. All of these are taken in the cycle of the readback command.
- R5: A data-port read returns and clears a pending status snapshot before any pending count snapshot. Without any snapshot pending, it returns live count bytes.
- R6: In low-then-high order, the first data write is only held. The second data write loads {second byte, first byte}.
- R7: Without a snapshot pending, a data read returns the live low byte in low-only order and the live high byte in high-only order. In low-then-high order, successive reads alternate between the low byte and the high byte, starting with the low byte.
- R8: A low-only write loads {8'h00, byte} and a high-only write loads {byte, 8'h00}. Every load shows as a one-cycle load pulse with the new reload value in the cycle after the write. Loads arise from data-port writes only.
- R9: While reset is held, and after it, every channel has mode 3, decimal flag 0, reload 0, low-then-high order, both toggles at the low byte and no snapshot pending. The gate outputs are 1, 1 and 0 for channels 0, 1 and 2 during reset, and afterwards follow the gate inputs with one cycle of delay.
- R10: A read of address 3, or of a channel number at or above NCH, returns 8'hFF and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, side effects at the closing edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| live_cnt | input | NCH*16 | Running count of each channel core |
| out_lvl | input | NCH | Output level of each channel core |
| gate_i | input | NCH | Requested gate level per channel |
| ch_reload | output | NCH*16 | Reload value per channel |
| ch_load | output | NCH | One-cycle load pulse per channel |
| ch_mode | output | NCH*3 | Counting mode per channel |
| ch_bcd | output | NCH | Decimal counting flag per channel |
| ch_gate | output | NCH | Gate level per channel |

## Verification
A wrong byte toggle shows up on the next data read as a swapped byte. The same fault on the write side shows up one cycle after the second write as a reload with its halves exchanged. A snapshot flag stuck set or cleared too early shows at the following read, which returns a live byte or status where a frozen one was expected, or the reverse. The reference model follows every channel on every clock edge, so a divergence is reported in the cycle of the first read or load that exposes it.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e               acc;
        logic [MODE_W-1:0]  mode;
        logic               bcd;
        logic               rd_hi;
        logic               wr_hi;
        logic [BYTE_W-1:0]  wr_hold;
        acc_e               snap;
        logic [CNT_W-1:0]   snap_val;
        logic               st_pend;
        logic [BYTE_W-1:0]  st_val;
        logic [CNT_W-1:0]   reload;
        logic               load;
    } chan_st_t;

endpackage

// File: rtl/tmr_regif_chan.sv
module tmr_regif_chan
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              rb_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  reload,
    output logic              load,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);

    localparam int HI_LSB = CNT_W - BYTE_W;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;

        if (ctl_wr) begin
            if (acc_e'(wbyte[5:4]) == ACC_LATCH) begin
                if (st_q.snap == ACC_LATCH) begin
                    st_d.snap     = st_q.acc;
                    st_d.snap_val = live;
                end
            end else begin
                st_d.acc   = acc_e'(wbyte[5:4]);
                st_d.mode  = wbyte[3:1];
                st_d.bcd   = wbyte[0];
                st_d.rd_hi = 1'b0;
                st_d.wr_hi = 1'b0;
            end
        end

        if (rb_wr) begin
            if (!wbyte[5] && st_q.snap == ACC_LATCH) begin
                st_d.snap     = st_q.acc;
                st_d.snap_val = live;
            end
            if (!wbyte[4] && !st_q.st_pend) begin
                st_d.st_pend = 1'b1;
                st_d.st_val  = {out_lvl, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
            end
        end

        if (dat_wr) begin
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.reload = {{HI_LSB{1'b0}}, wbyte};
                    st_d.load   = 1'b1;
                end
                ACC_HI: begin
                    st_d.reload = {wbyte, {HI_LSB{1'b0}}};
                    st_d.load   = 1'b1;
                end
                default: begin
                    if (!st_q.wr_hi) begin
                        st_d.wr_hold = wbyte;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        st_d.reload = {wbyte, st_q.wr_hold};
                        st_d.load   = 1'b1;
                        st_d.wr_hi  = 1'b0;
                    end
                end
            endcase
        end

        if (dat_rd) begin
            if (st_q.st_pend) begin
                st_d.st_pend = 1'b0;
            end else if (st_q.snap == ACC_WORD) begin
                st_d.snap = ACC_HI;
            end else if (st_q.snap != ACC_LATCH) begin
                st_d.snap = ACC_LATCH;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = ~st_q.rd_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.acc  <= ACC_WORD;
            st_q.mode <= MODE_W'(3);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.st_pend)
            rd_byte = st_q.st_val;
        else if (st_q.snap == ACC_LO || st_q.snap == ACC_WORD)
            rd_byte = st_q.snap_val[BYTE_W-1:0];
        else if (st_q.snap == ACC_HI)
            rd_byte = st_q.snap_val[CNT_W-1:HI_LSB];
        else if (st_q.acc == ACC_HI || (st_q.acc == ACC_WORD && st_q.rd_hi))
            rd_byte = live[CNT_W-1:HI_LSB];
        else
            rd_byte = live[BYTE_W-1:0];
    end

    assign reload = st_q.reload;
    assign load   = st_q.load;
    assign mode   = st_q.mode;
    assign bcd    = st_q.bcd;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int             NCH      = 3,
    parameter int             ADDR_W   = 2,
    parameter logic [NCH-1:0] GATE_RST = NCH'(3'b011)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [NCH*CNT_W-1:0]  live_cnt,
    input  logic [NCH-1:0]        out_lvl,
    input  logic [NCH-1:0]        gate_i,
    output logic [NCH*CNT_W-1:0]  ch_reload,
    output logic [NCH-1:0]        ch_load,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ch_bcd,
    output logic [NCH-1:0]        ch_gate
);

    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(3);
    localparam logic [1:0]        SEL_RB   = 2'd3;

    logic              ctl_hit;
    logic              rb_hit;
    logic [BYTE_W-1:0] rd_byte [NCH];
    logic [NCH-1:0]    gate_d, gate_q;

    assign ctl_hit = bus_wr && bus_addr == CTL_ADDR;
    assign rb_hit  = ctl_hit && bus_wdata[7:6] == SEL_RB;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_regif_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (ctl_hit && bus_wdata[7:6] == 2'(i)),
            .rb_wr   (rb_hit && bus_wdata[i+1]),
            .dat_wr  (bus_wr && bus_addr == ADDR_W'(i)),
            .dat_rd  (bus_rd && bus_addr == ADDR_W'(i)),
            .wbyte   (bus_wdata),
            .live    (live_cnt[i*CNT_W +: CNT_W]),
            .out_lvl (out_lvl[i]),
            .rd_byte (rd_byte[i]),
            .reload  (ch_reload[i*CNT_W +: CNT_W]),
            .load    (ch_load[i]),
            .mode    (ch_mode[i*MODE_W +: MODE_W]),
            .bcd     (ch_bcd[i])
        );
    end

    always_comb begin
        bus_rdata = '1;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(i))
                bus_rdata = rd_byte[i];
        end
    end

    always_comb gate_d = gate_i;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= GATE_RST;
        else        gate_q <= gate_d;
    end

    assign ch_gate = gate_q;

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [NCH-1:0]    gate_i,
    input logic [NCH-1:0]    ch_load,
    input logic [NCH*3-1:0]  ch_mode,
    input logic [NCH-1:0]    ch_gate
);

    AST_IDLE_ADDR_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(3)) |-> bus_rdata == 8'hFF); // R10

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] != 2'd0)
            |=> ch_mode[i*3 +: 3] == $past(bus_wdata[3:1])); // R1

        AST_LOAD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            ch_load[i] |-> $past(bus_wr && bus_addr == ADDR_W'(i))); // R8

        AST_GATE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ch_gate[i] == $past(gate_i[i])); // R9
    end

endmodule

bind tmr_regif tmr_regif_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gate_i    (gate_i),
    .ch_load   (ch_load),
    .ch_mode   (ch_mode),
    .ch_gate   (ch_gate)
);

// File: tb/tmr_regif_bench.sv
`timescale 1ns/1ps
module tmr_regif_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic [47:0] live_cnt = 0;
    logic [2:0]  out_lvl = 0, gate_i = 0;
    logic [47:0] ch_reload;
    logic [2:0]  ch_load, ch_bcd, ch_gate;
    logic [8:0]  ch_mode;

    int total = 0, bad = 0;
    bit done = 0;

    int m_acc[3], m_md[3], m_bcd[3], m_rdhi[3], m_wrhi[3], m_hold[3];
    int m_snap[3], m_sval[3], m_sp[3], m_stv[3], m_rl[3], m_ld[3], m_gt[3];

    always #2 clk = ~clk;

    tmr_regif u_tmr_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_cnt(live_cnt), .out_lvl(out_lvl), .gate_i(gate_i),
        .ch_reload(ch_reload), .ch_load(ch_load), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ch_gate(ch_gate)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int live(int i);
        return int'(live_cnt[i*16 +: 16]);
    endfunction

    function automatic int exp_rd(int a);
        if (a > 2) return 255;
        if (m_sp[a] != 0) return m_stv[a];
        if (m_snap[a] == 1 || m_snap[a] == 3) return m_sval[a] & 255;
        if (m_snap[a] == 2) return m_sval[a] >> 8;
        if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rdhi[a] != 0)) return live(a) >> 8;
        return live(a) & 255;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_acc[i] = 3; m_md[i] = 3; m_bcd[i] = 0; m_rdhi[i] = 0; m_wrhi[i] = 0;
            m_hold[i] = 0; m_snap[i] = 0; m_sval[i] = 0; m_sp[i] = 0; m_stv[i] = 0;
            m_rl[i] = 0; m_ld[i] = 0; m_gt[i] = (i != 2) ? 1 : 0;
        end
    endtask

    task automatic snap_take(int i);
        if (m_snap[i] == 0) begin
            m_snap[i] = m_acc[i];
            m_sval[i] = live(i);
        end
    endtask

    task automatic model_step();
        int a = int'(bus_addr);
        int d = int'(bus_wdata);
        for (int i = 0; i < 3; i++) m_ld[i] = 0;
        if (bus_wr && a == 3) begin
            int sel = (d >> 6) & 3;
            int ac  = (d >> 4) & 3;
            if (sel == 3) begin
                for (int i = 0; i < 3; i++) begin
                    if (((d >> (i + 1)) & 1) != 0) begin
                        if ((d & 32) == 0) snap_take(i);
                        if ((d & 16) == 0 && m_sp[i] == 0) begin
                            m_sp[i]  = 1;
                            m_stv[i] = (int'(out_lvl[i]) << 7) | (m_acc[i] << 4) | (m_md[i] << 1) | m_bcd[i];
                        end
                    end
                end
            end else if (ac == 0) begin
                snap_take(sel);
            end else begin
                m_acc[sel] = ac; m_md[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
                m_rdhi[sel] = 0; m_wrhi[sel] = 0;
            end
        end else if (bus_wr) begin
            if (m_acc[a] == 1) begin m_rl[a] = d; m_ld[a] = 1; end
            else if (m_acc[a] == 2) begin m_rl[a] = d << 8; m_ld[a] = 1; end
            else if (m_wrhi[a] == 0) begin m_hold[a] = d; m_wrhi[a] = 1; end
            else begin m_rl[a] = (d << 8) | m_hold[a]; m_ld[a] = 1; m_wrhi[a] = 0; end
        end
        if (bus_rd && a < 3) begin
            if (m_sp[a] != 0) m_sp[a] = 0;
            else if (m_snap[a] == 3) m_snap[a] = 2;
            else if (m_snap[a] != 0) m_snap[a] = 0;
            else if (m_acc[a] == 3) m_rdhi[a] ^= 1;
        end
        for (int i = 0; i < 3; i++) m_gt[i] = int'(gate_i[i]);
    endtask

    task automatic cmp_outs();
        for (int i = 0; i < 3; i++) begin
            chk("R8 load", int'(ch_load[i]), m_ld[i]);
            chk("R6 reload", int'(ch_reload[i*16 +: 16]), m_rl[i]);
            chk("R1 mode", int'(ch_mode[i*3 +: 3]), m_md[i]);
            chk("R1 bcd", int'(ch_bcd[i]), m_bcd[i]);
            chk("R9 gate", int'(ch_gate[i]), m_gt[i]);
        end
    endtask

    task automatic step(bit w, bit r, int a, int d, string tag);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = 2'(a); bus_wdata = 8'(d);
        live_cnt = {16'($urandom), 16'($urandom), 16'($urandom)};
        out_lvl = 3'($urandom);
        gate_i = 3'($urandom);
        #1;
        if (r) chk(tag, int'(bus_rdata), exp_rd(a));
        @(posedge clk);
        #1;
        model_step();
        cmp_outs();
    endtask

    task automatic wr(int a, int d);
        step(1, 0, a, d, "");
    endtask

    task automatic rd(int a, string tag);
        step(0, 1, a, 0, tag);
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R9 mode", int'(ch_mode), 9'h0DB);
        chk("R9 reload", int'(ch_reload), 0);
        chk("R9 gate", int'(ch_gate), 3);
        chk("R9 load", int'(ch_load), 0);
        @(negedge clk);
        rst_n = 1;
        rd(0, "R9 first low"); rd(0, "R9 then high");
        wr(0, 8'h34); wr(0, 8'hCD); wr(0, 8'hAB);
        wr(3, 8'h51); wr(1, 8'h5A);
        wr(3, 8'hAA); wr(2, 8'h12);
        rd(0, "R7 word low"); rd(0, "R7 word high"); rd(0, "R7 word low again");
        rd(1, "R7 low only"); rd(2, "R7 high only");
        wr(3, 8'h00); wr(3, 8'h00);
        rd(0, "R2 snap low"); rd(0, "R2 snap high"); rd(0, "R2 live after");
        wr(3, 8'h80); wr(3, 8'h80);
        rd(2, "R2 snap high only"); rd(2, "R2 live high");
        wr(3, 8'hCE);
        rd(0, "R5 status first"); rd(0, "R2 count low"); rd(0, "R2 count high");
        rd(1, "R4 status ch1"); rd(1, "R2 count ch1");
        rd(2, "R4 status ch2"); rd(2, "R2 count ch2");
        wr(3, 8'hE2); wr(3, 8'hE2);
        rd(0, "R3 status kept"); rd(0, "R3 status gone");
        wr(3, 8'hDC); rd(1, "R3 count only"); rd(2, "R3 count only");
        rd(3, "R10 addr3"); rd(3, "R10 addr3 again"); rd(0, "R10 no effect");
        wr(0, 8'h11); wr(3, 8'h34); wr(0, 8'h22); wr(0, 8'h33);
        rd(0, "R1 toggle reset");
        for (int k = 0; k < 3000; k++) begin
            int op = int'($urandom % 3);
            int a  = int'($urandom % 4);
            if (op == 0) rd(a, "R7 random read");
            else if (op == 1) wr(a, int'($urandom % 256));
            else step(0, 0, 0, 0, "");
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule